// File: doc/BRIEF.md
# Register-Driven Byte SPI Master

This block is a small SPI master that a processor drives through two 32-bit registers. A control register at byte offset 0x0 holds the chip-select levels, a loopback switch, a clock-divider value and a start bit. When read, it returns a busy flag in place of the start bit. A data register at byte offset 0x4 takes the byte to transmit and returns the byte most recently received. Each accepted start command exchanges exactly one byte, full duplex, in SPI mode 0 with the most significant bit first.

Chip selects are plain register bits that drive the pins directly. The block frames nothing by itself: software raises and lowers the selects around a run of bytes. Each control write replaces every field at once. A start command is accepted only when the engine is idle. The serial clock is the bus clock divided by 2*(N+1), where N is the divider field.

The shift engine is a three-state machine:
- ST_IDLE: no transfer; SCLK low.
- ST_LOW: SCLK low while the current MOSI bit settles.
- ST_HIGH: SCLK high after MISO has been sampled.

Its transitions are:
- GO: ST_IDLE to ST_LOW on an accepted start.
- RISE: ST_LOW to ST_HIGH when a half-period ends.
- FALL_NEXT: ST_HIGH to ST_LOW at the end of a half-period when bits remain.
- FALL_LAST: ST_HIGH to ST_IDLE at the end of the eighth high phase.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control register reads 0x00000015, the data register reads 0, all three chip-select outputs are high and SCLK is low.
- R2: A write of the control register (byte address 0x0) with bit 1 set, while idle, starts a transfer. Control bit 1 then reads 1 for exactly 16*(N+1) bus-clock cycles and reads 0 afterwards. The start bit itself is never stored.
- R3: Chip-select outputs 0, 1 and 2 follow control bits 0, 2 and 4. They change only when the control register is written, and they hold steady through transfers.
- R4: During a transfer, SCLK produces exactly 8 rising edges spaced 2*(N+1) bus-clock cycles apart, where N is control bits [31:27]. This holds for every N from 0 to 31.
- R5: SPI mode 0, MSB first. SCLK idles low, MOSI changes only while SCLK is low, and MOSI carries the transmit byte starting with bit 7.
- R6: MISO is sampled on each SCLK rising edge, MSB first. Once busy reads 0, the data register (byte address 0x4) returns the received byte in bits [7:0], with bits [31:8] zero.
- R7: When control bit 3 is set, the receive path takes MOSI instead of MISO, so the received byte equals the transmitted byte whatever MISO does.
- R8: A control write with bit 1 set while busy reads 1 starts nothing. The current transfer keeps its 16*(N+1)-cycle length and its 8 SCLK edges.
- R9: Every control write latches the chip-select, loopback and divider fields together. Reading the control register returns bits [31:27], 4, 3, 2 and 0 as last written, busy in bit 1, and zero in every other bit.
- R10: Only bits [7:0] of a data-register write are kept as the transmit byte. The upper bits have no effect on MOSI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the serial reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address: 0x0 control, 0x4 data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select levels, software owned |

## Verification
Two functions can act in the same cycle: the field latch of a control write and the start gate that refuses a second start while the engine is busy. The bench places a full control write with the start bit in the middle of a divide-by-eight transfer. It then judges the outcome from the total busy length of 64 cycles, the count of 8 SCLK rises and the unchanged chip-select pins. Every divider value from 0 to 31 is swept, and each transfer's timing, MOSI byte and received byte are compared against values computed from N.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int BUS_W     = 32;
    localparam int START_BIT = 1;
    localparam int LOOP_BIT  = 3;
    localparam int CTRL_OFF  = 0;
    localparam int DATA_OFF  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sbm_state_t;
endpackage

// File: rtl/sbm_regs.sv
module sbm_regs
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 5,
    parameter int NUM_CS = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CS-1:0] cs_lvl,
    output logic              loop_en,
    output logic [DIV_W-1:0]  div_val,
    output logic [DATA_W-1:0] tx_byte,
    output logic              start
);
    localparam int DIV_LO = BUS_W - DIV_W;

    logic ctrl_hit;
    logic data_hit;
    logic ctrl_wr;
    logic [BUS_W-1:0] ctrl_word;
    logic unused_wdata_mid;

    assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_OFF));
    assign data_hit = (bus_addr == ADDR_W'(DATA_OFF));
    assign ctrl_wr  = bus_wr && ctrl_hit;
    assign start    = ctrl_wr && bus_wdata[START_BIT] && !busy;
    assign unused_wdata_mid = ^bus_wdata[DIV_LO-1:DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_lvl  <= '1;
            loop_en <= 1'b0;
            div_val <= '0;
            tx_byte <= '0;
        end else begin
            if (ctrl_wr) begin
                for (int i = 0; i < NUM_CS; i++) begin
                    cs_lvl[i] <= bus_wdata[2*i];
                end
                loop_en <= bus_wdata[LOOP_BIT];
                div_val <= bus_wdata[BUS_W-1 -: DIV_W];
            end
            if (bus_wr && data_hit) begin
                tx_byte <= bus_wdata[DATA_W-1:0];
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            ctrl_word[2*i] = cs_lvl[i];
        end
        ctrl_word[LOOP_BIT]          = loop_en;
        ctrl_word[START_BIT]         = busy;
        ctrl_word[BUS_W-1 -: DIV_W]  = div_val;
        if (ctrl_hit) begin
            bus_rdata = ctrl_word;
        end else if (data_hit) begin
            bus_rdata = BUS_W'(rx_byte);
        end else begin
            bus_rdata = '0;
        end
    end

    AST_CS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cs_lvl)); // R3

    AST_DIV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(div_val)); // R9
endmodule

// File: rtl/sbm_clkdiv.sv
module sbm_clkdiv #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HALF_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0)); // R4
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter
    import sbm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    input  logic              loop_en,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sbm_state_t state;
    sbm_state_t nxt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sin;

    assign sin  = loop_en ? mosi : miso;
    assign mosi = tx_sh[DATA_W-1];
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LOW;
            ST_LOW:  if (tick)  nxt = ST_HIGH;
            ST_HIGH: if (tick)  nxt = (bit_cnt == LAST_BIT) ? ST_IDLE : ST_LOW;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk <= 1'b0;
                    if (start) begin
                        tx_sh   <= tx_byte;
                        bit_cnt <= '0;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[DATA_W-2:0], sin};
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bit_cnt == LAST_BIT) begin
                            rx_byte <= rx_sh;
                        end else begin
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: sclk <= 1'b0;
            endcase
        end
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R2

    AST_SCLK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R5

    AST_MOSI_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi)); // R5

    AST_LAST_FALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && tick && bit_cnt == LAST_BIT) |=> !busy); // R2
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 5,
    parameter int NUM_CS = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    logic              busy;
    logic              start;
    logic              tick;
    logic              loop_en;
    logic [DIV_W-1:0]  div_val;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;

    sbm_regs #(
        .ADDR_W(ADDR_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS), .DATA_W(DATA_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .busy(busy), .rx_byte(rx_byte), .bus_rdata(bus_rdata),
        .cs_lvl(spi_cs), .loop_en(loop_en), .div_val(div_val),
        .tx_byte(tx_byte), .start(start)
    );

    sbm_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .div_val(div_val), .tick(tick)
    );

    sbm_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .tick(tick), .miso(spi_miso), .loop_en(loop_en),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy), .rx_byte(rx_byte)
    );

    AST_BUSY_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == ADDR_W'(CTRL_OFF) && bus_wdata[START_BIT] && !tick)
        |=> busy); // R8
endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [2:0]  cs;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int per_bad = 0;
    int exp_per = 2;
    int cs_chg = 0;
    int idx = 0;
    logic [7:0] mon = '0;
    logic [7:0] slv = '0;
    logic sclk_q = 1'b0;
    logic [2:0] cs_q = 3'b111;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs)
    );

    always @(negedge clk) begin
        cyc++;
        if (sclk && !sclk_q) begin
            if (rises != 0 && (cyc - last_rise) != exp_per) per_bad++;
            rises++;
            last_rise = cyc;
            mon = {mon[6:0], mosi};
        end
        if (!sclk && sclk_q) begin
            idx++;
            if (idx < 8) miso = slv[7-idx];
        end
        if (cs !== cs_q) cs_chg++;
        sclk_q = sclk;
        cs_q = cs;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [31:0] ctrl_val(input int n, input logic [2:0] c, input bit lp);
        return (32'(n) << 27) | (32'(c[2]) << 4) | (32'(c[1]) << 2) | 32'(c[0]) | (32'(lp) << 3);
    endfunction

    task automatic arm(input int n, input logic [7:0] s);
        rises = 0; per_bad = 0; cs_chg = 0; mon = '0;
        exp_per = 2 * (n + 1);
        slv = s; idx = 0; miso = s[7];
    endtask

    task automatic xfer(input int n, input logic [2:0] c, input bit lp,
                        input logic [31:0] txw, input logic [7:0] s);
        logic [31:0] d;
        int cnt;
        logic [7:0] txb;
        txb = txw[7:0];
        wr_reg(3'd0, ctrl_val(n, c, lp));
        wr_reg(3'd4, txw);
        arm(n, s);
        wr_reg(3'd0, ctrl_val(n, c, lp) | 32'h2);
        cnt = 0;
        while (rdata[1] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 16 * (n + 1), "R2", "busy length", cnt, 16 * (n + 1));
        chk(rises == 8, "R4", "sclk rises", rises, 8);
        chk(per_bad == 0, "R4", "sclk period mismatches", per_bad, 0);
        chk(mon == txb, "R5", "mosi byte", mon, txb);
        chk(cs_chg == 0 && cs == c, "R3", "cs held", {cs_chg[28:0], cs}, c);
        rd_reg(3'd4, d);
        if (lp) chk(d == 32'(txb), "R7", "loopback rx", d, 32'(txb));
        else    chk(d == 32'(s), "R6", "rx byte", d, 32'(s));
        rd_reg(3'd0, d);
        chk(d == ctrl_val(n, c, lp), "R9", "ctrl readback", d, ctrl_val(n, c, lp));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(3'd0, d);
        chk(d == 32'h15, "R1", "ctrl after reset", d, 32'h15);
        rd_reg(3'd4, d);
        chk(d == 32'h0, "R1", "data after reset", d, 32'h0);
        chk(cs == 3'b111 && sclk == 1'b0, "R1", "pins after reset", {28'h0, sclk, cs}, 32'h7);

        for (int c = 0; c < 8; c++) begin
            wr_reg(3'd0, ctrl_val(c * 4, 3'(c), c[0]) | 32'h07FF_FFE0);
            rd_reg(3'd0, d);
            chk(d == ctrl_val(c * 4, 3'(c), c[0]), "R9", "field latch", d, ctrl_val(c * 4, 3'(c), c[0]));
            chk(cs == 3'(c), "R3", "cs pins", {29'h0, cs}, 32'(c));
        end

        for (int n = 0; n < 32; n++) begin
            logic [7:0] t;
            t = 8'((n * 37 + 5) & 255);
            xfer(n, 3'(n % 8), (n % 4) == 3, {24'hA5A5A5, t}, t ^ 8'hC3 ^ 8'(n));
        end

        xfer(1, 3'b010, 1'b0, 32'hABCDEF5A, 8'h81);
        chk(mon == 8'h5A, "R10", "upper data bits ignored", mon, 32'h5A);

        wr_reg(3'd0, ctrl_val(3, 3'b101, 1'b0));
        wr_reg(3'd4, 32'h0000_003C);
        arm(3, 8'h96);
        wr_reg(3'd0, ctrl_val(3, 3'b101, 1'b0) | 32'h2);
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin
            if (!rdata[1]) break;
            cnt++;
            wr = (i == 20);
            @(negedge clk);
        end
        wr = 1'b0;
        chk(cnt == 64, "R8", "busy length with refused start", cnt, 64);
        chk(rises == 8, "R8", "sclk rises with refused start", rises, 8);
        chk(cs_chg == 0, "R3", "cs during refused start", cs_chg, 0);
        repeat (40) @(negedge clk);
        chk(rises == 8 && sclk == 1'b0, "R8", "no second transfer", rises, 8);
        rd_reg(3'd4, d);
        chk(d == 32'h96, "R6", "rx after refused start", d, 32'h96);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule